// File: doc/BRIEF.md
# Aging-Counter Page Replacement Tracker

This block approximates least-recently-used page replacement for a small set of physical page frames. Each frame owns a one-bit "referenced" latch, set by a reference pulse from the memory access path, and an aging counter. On every periodic tick, each counter moves one place toward its least significant end. The frame's latched reference bit becomes the new top bit, and the latch is then cleared. The counter therefore holds the reference history of the last AGE_W ticks, and a recent reference outweighs any number of older ones.

When the replacement logic needs a frame to evict, it pulses a victim request. A minimum search across all counters runs in the same cycle. On the next cycle the block presents the index of the frame with the smallest counter, together with a valid flag. When a new page is loaded into a frame, a per-frame clear wipes both that frame's counter and its reference latch. The block holds neither the frame contents nor any translation state.

Top module: `aging_lru_tracker`

## Requirements
- R1: After reset every counter and reference latch is zero, `victim_vld_o` is low, and a first victim request returns frame 0.
- R2: On a tick, each uncleared frame's counter becomes its old value shifted right by one, with the reference latch value in the most significant bit (bit AGE_W-1).
- R3: A tick clears every reference latch after sampling, so a frame that was not referenced between two ticks gets a 0 in the top bit on the second tick.
- R4: A reference that arrives in the same cycle as a tick does not enter that tick's top bit. It stays latched and is shifted in at the following tick.
- R5: `victim_vld_o` is high exactly in the cycle after a cycle with `victim_req_i` high. `victim_idx_o` then names a frame whose counter, as it stood in the request cycle, is the smallest. It holds its value while no request arrives.
- R6: When several frames share the minimum counter value, the lowest-numbered one is chosen.
- R7: `frame_clr_i[f]` zeroes frame f's counter and reference latch. It takes priority over a reference to, or a tick on, the same frame in the same cycle.
- R8: A frame with no reference for AGE_W consecutive ticks ends with a counter of zero, and cannot be told apart from a frame that was never referenced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | NUM_FRAMES | Per-frame reference pulse; bit f sets frame f's latch |
| tick_i | input | 1 | Aging tick; shifts all counters and clears the latches |
| frame_clr_i | input | NUM_FRAMES | Per-frame clear on page load |
| victim_req_i | input | 1 | Request for a replacement victim |
| victim_vld_o | output | 1 | Victim index valid, one cycle after a request |
| victim_idx_o | output | $clog2(NUM_FRAMES) | Index of the frame with the lowest counter |

## Verification
The first directed patterns reference every frame except one before a tick. This separates a correct shift-in of the reference bit from a stuck or inverted one. A reference placed in the tick cycle itself checks whether it is counted one tick late or lost. A frame referenced only at the latest tick is compared with frames referenced at many older ticks, which checks that recency outweighs frequency. A run of eight idle ticks and a fully tied state check that old history is forgotten and that the lowest index wins a tie. Clears issued together with references and ticks on the same frame test clear priority. A long random phase mixes all inputs and compares the victim output with a behavioural model on every clock.

// File: rtl/aging_lru_pkg.sv
package aging_lru_pkg;

  // Width of a frame index; at least one bit.
  function automatic int unsigned idx_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/alru_ref_latch.sv
module alru_ref_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic r_o
);

  logic r_q;
  logic r_d;
  logic r_en;

  // Priority: clear, then a new reference, then the tick's clear.
  always_comb begin
    r_en = clr_i | ref_i | tick_i;
    r_d  = r_q;
    if (tick_i) r_d = 1'b0;
    if (ref_i)  r_d = 1'b1;
    if (clr_i)  r_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= 1'b0;
    end else if (r_en) begin
      r_q <= r_d;
    end
  end

  assign r_o = r_q;

endmodule

// File: rtl/alru_age_counter.sv
module alru_age_counter #(
  parameter int unsigned AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             r_i,
  output logic [AGE_W-1:0] age_o
);

  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] age_d;
  logic             age_en;

  always_comb begin
    age_en = clr_i | tick_i;
    age_d  = age_q;
    if (tick_i) age_d = {r_i, age_q[AGE_W-1:1]};
    if (clr_i)  age_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_en) begin
      age_q <= age_d;
    end
  end

  assign age_o = age_q;

endmodule

// File: rtl/alru_min_tree.sv
module alru_min_tree
  import aging_lru_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 8,
  parameter int unsigned AGE_W      = 8,
  localparam int unsigned IDX_W     = idx_width(NUM_FRAMES)
) (
  input  logic [NUM_FRAMES-1:0][AGE_W-1:0] ages_i,
  output logic [IDX_W-1:0]                 min_idx_o,
  output logic [AGE_W-1:0]                 min_age_o
);

  localparam int unsigned LEAVES = 1 << IDX_W;

  for (genvar l = 0; l <= IDX_W; l++) begin : g_lvl
    localparam int unsigned WIDTH = LEAVES >> l;
    logic [AGE_W-1:0] lv_age [WIDTH];
    logic [IDX_W-1:0] lv_idx [WIDTH];

    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < WIDTH; j++) begin : g_in
        if (j < NUM_FRAMES) begin : g_real
          assign lv_age[j] = ages_i[j];
        end else begin : g_pad
          assign lv_age[j] = '1;
        end
        assign lv_idx[j] = IDX_W'(j);
      end
    end else begin : g_node
      for (genvar j = 0; j < WIDTH; j++) begin : g_cmp
        logic take_right;
        // Left child always carries lower indices: keep it on a tie.
        assign take_right = g_lvl[l-1].lv_age[2*j+1] < g_lvl[l-1].lv_age[2*j];
        assign lv_age[j]  = take_right ? g_lvl[l-1].lv_age[2*j+1] : g_lvl[l-1].lv_age[2*j];
        assign lv_idx[j]  = take_right ? g_lvl[l-1].lv_idx[2*j+1] : g_lvl[l-1].lv_idx[2*j];
      end
    end
  end

  assign min_idx_o = g_lvl[IDX_W].lv_idx[0];
  assign min_age_o = g_lvl[IDX_W].lv_age[0];

endmodule

// File: rtl/aging_lru_tracker.sv
module aging_lru_tracker
  import aging_lru_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 8,
  parameter int unsigned AGE_W      = 8,
  localparam int unsigned IDX_W     = idx_width(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FRAMES-1:0] ref_i,
  input  logic                  tick_i,
  input  logic [NUM_FRAMES-1:0] frame_clr_i,
  input  logic                  victim_req_i,
  output logic                  victim_vld_o,
  output logic [IDX_W-1:0]      victim_idx_o
);

  logic [NUM_FRAMES-1:0]            r_vec;
  logic [NUM_FRAMES-1:0][AGE_W-1:0] age_vec;
  logic [IDX_W-1:0]                 min_idx;
  logic [AGE_W-1:0]                 min_age;

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    alru_ref_latch u_rlat (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_i  (ref_i[f]),
      .tick_i (tick_i),
      .clr_i  (frame_clr_i[f]),
      .r_o    (r_vec[f])
    );

    alru_age_counter #(.AGE_W(AGE_W)) u_age (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .clr_i  (frame_clr_i[f]),
      .r_i    (r_vec[f]),
      .age_o  (age_vec[f])
    );
  end

  alru_min_tree #(.NUM_FRAMES(NUM_FRAMES), .AGE_W(AGE_W)) u_min (
    .ages_i    (age_vec),
    .min_idx_o (min_idx),
    .min_age_o (min_age)
  );

  // Victim result register
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    vld_d = victim_req_i;
    idx_d = idx_q;
    if (victim_req_i) idx_d = min_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (victim_req_i) begin
      idx_q <= idx_d;
    end
  end

  assign victim_vld_o = vld_q;
  assign victim_idx_o = idx_q;

endmodule

// File: rtl/alru_checker.sv
module alru_checker #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         ref_i,
  input logic                 tick_i,
  input logic [N-1:0]         clr_i,
  input logic                 req_i,
  input logic                 vld_o,
  input logic [IW-1:0]        idx_o,
  input logic [N-1:0]         r_vec,
  input logic [N-1:0][W-1:0]  age_vec,
  input logic [W-1:0]         min_age
);

  logic [N-1:0][W-1:0] ages_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ages_q <= '0;
    else        ages_q <= age_vec;
  end

  a_r5_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o);
  a_r5_no_vld_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !vld_o);
  a_r5_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(idx_o));
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (int'(idx_o) < N));

  for (genvar f = 0; f < N; f++) begin : g_chk
    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !clr_i[f]) |=> age_vec[f] == {$past(r_vec[f]), $past(age_vec[f][W-1:1])});
    a_r3_tick_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ref_i[f]) |=> !r_vec[f]);
    a_r4_ref_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_i[f] && !clr_i[f]) |=> r_vec[f]);
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[f] |=> (age_vec[f] == '0) && !r_vec[f]);
    a_r5_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
      min_age <= age_vec[f]);
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (ages_q[f] > ages_q[idx_o]) ||
                ((ages_q[f] == ages_q[idx_o]) && (f >= int'(idx_o))));
  end

endmodule

bind aging_lru_tracker alru_checker #(.N(NUM_FRAMES), .W(AGE_W), .IW(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_i   (ref_i),
  .tick_i  (tick_i),
  .clr_i   (frame_clr_i),
  .req_i   (victim_req_i),
  .vld_o   (victim_vld_o),
  .idx_o   (victim_idx_o),
  .r_vec   (r_vec),
  .age_vec (age_vec),
  .min_age (min_age)
);

// File: tb/aging_lru_tracker_tb.sv
module aging_lru_tracker_tb;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ref_i;
  logic          tick_i;
  logic [N-1:0]  frame_clr_i;
  logic          victim_req_i;
  logic          victim_vld_o;
  logic [IW-1:0] victim_idx_o;

  always #2.5 clk = ~clk;

  aging_lru_tracker #(.NUM_FRAMES(N), .AGE_W(W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_i        (ref_i),
    .tick_i       (tick_i),
    .frame_clr_i  (frame_clr_i),
    .victim_req_i (victim_req_i),
    .victim_vld_o (victim_vld_o),
    .victim_idx_o (victim_idx_o)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural model: integer history and one flag per frame
  int m_age [N];
  bit m_ref [N];
  int exp_idx = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int model_victim();
    int best = 0;
    for (int f = 1; f < N; f++) if (m_age[f] < m_age[best]) best = f;
    return best;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, advance model, compare at next negedge.
  task automatic cycle(input logic [N-1:0] rf, input logic tk,
                       input logic [N-1:0] cl, input logic rq, input string tag);
    ref_i = rf; tick_i = tk; frame_clr_i = cl; victim_req_i = rq;
    if (rq) exp_idx = model_victim();
    for (int f = 0; f < N; f++) begin
      if (cl[f]) begin
        m_age[f] = 0;
        m_ref[f] = 0;
      end else begin
        if (tk) begin
          m_age[f] = (m_age[f] / 2) + (m_ref[f] ? (1 << (W-1)) : 0);
          m_ref[f] = 0;
        end
        if (rf[f]) m_ref[f] = 1;
      end
    end
    @(negedge clk);
    check({tag, " vld"}, int'(victim_vld_o), int'(rq));
    check({tag, " idx"}, int'(victim_idx_o), exp_idx);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle('0, 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    ref_i = '0; tick_i = 1'b0; frame_clr_i = '0; victim_req_i = 1'b0;
    for (int f = 0; f < N; f++) begin m_age[f] = 0; m_ref[f] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset vld", int'(victim_vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cycle('0, 1'b0, '0, 1'b1, "R1 first victim");
    check("R1 first victim is frame 0", int'(victim_idx_o), 0);

    // R2: all but frame 5 referenced, then tick
    cycle(8'hDF, 1'b0, '0, 1'b0, "R2 refs");
    cycle('0, 1'b1, '0, 1'b0, "R2 tick");
    cycle('0, 1'b0, '0, 1'b1, "R2 victim");
    check("R2 unreferenced frame chosen", int'(victim_idx_o), 5);

    // R3: only frame 5 referenced; recency (128) beats older (64)
    cycle(8'h20, 1'b0, '0, 1'b0, "R3 ref");
    cycle('0, 1'b1, '0, 1'b1, "R3 tick+req");
    cycle('0, 1'b0, '0, 1'b1, "R3 victim");
    check("R3 stale frames lose top bit", int'(victim_idx_o), 0);

    // R4: reference to frame 6 in the tick cycle is delayed one tick
    cycle(8'hBF, 1'b0, '0, 1'b0, "R4 refs");
    cycle(8'h40, 1'b1, '0, 1'b0, "R4 tick with ref");
    cycle('0, 1'b0, '0, 1'b1, "R4 victim");
    check("R4 same-cycle ref not yet counted", int'(victim_idx_o), 6);
    cycle('0, 1'b1, '0, 1'b0, "R4 next tick");
    cycle('0, 1'b0, '0, 1'b1, "R4 victim2");

    // R8: eight idle ticks erase history; R6 tie goes to frame 0
    for (int i = 0; i < W; i++) cycle('0, 1'b1, '0, 1'b0, "R8 idle tick");
    cycle('0, 1'b0, '0, 1'b1, "R8 victim");
    check("R8 R6 all zero -> frame 0", int'(victim_idx_o), 0);

    // R6: frames 0 and 1 referenced, tie among the rest -> 2
    cycle(8'h03, 1'b1, '0, 1'b0, "R6 ref");
    cycle('0, 1'b1, '0, 1'b0, "R6 tick");
    cycle('0, 1'b0, '0, 1'b1, "R6 victim");
    check("R6 lowest tied index", int'(victim_idx_o), 2);

    // R7: all referenced; clear frame 4 while it is referenced and ticked
    cycle(8'hFF, 1'b0, '0, 1'b0, "R7 refs");
    cycle(8'hFF, 1'b1, 8'h10, 1'b0, "R7 clear+ref+tick");
    cycle('0, 1'b1, '0, 1'b0, "R7 tick");
    cycle('0, 1'b0, '0, 1'b1, "R7 victim");
    check("R7 cleared frame chosen", int'(victim_idx_o), 4);
    idle(3, "R5 hold");

    // Random phase against the model, all requirements
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] rf, cl;
      rf = N'($urandom) & N'($urandom);
      cl = (($urandom % 8) == 0) ? N'(1 << ($urandom % N)) : '0;
      cycle(rf, (($urandom % 4) == 0), cl, (($urandom % 3) == 0), "R2 R5 R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule